// File: doc/BRIEF.md
# SDRAM Read-Latency and Byte-Mask Output Pipeline

This block is the data-output side of a synchronous DRAM model. The array side delivers one read word per burst beat together with a beat strobe. The block holds each word for a programmable read latency of one, two or three clocks, then presents it on a 16-bit output with one enable per byte lane. A separate write path registers incoming write words with per-byte write enables taken from the mask inputs.

Command decoding lives outside. It reaches this block only as single-cycle strobes: start of a new read, a continuing read beat, a write beat, a precharge and a burst stop. From these strobes the block works out which read beats still reach the pins. It also works out when the output floats after a burst ends early.

The two mask bits behave differently on the two paths. On a read, a mask bit removes its byte lane from the output two clocks after it is sampled. On a write, a mask bit blocks its byte in the same clock the data is sampled.

Top module: `sdram_rdout_pipe`

## Requirements
- R1: During and right after a synchronous active-low reset, `dq_oe`, `dq_out`, `wr_en` and `wr_be` are all zero, and the pipeline is closed, so no read beat is accepted until a read start.
- R2: With `lat_mode` equal to 1, 2 or 3, the word of a read beat accepted at clock edge n is driven in cycle n+L, where L is the value of `lat_mode`.
- R3: A `lat_mode` value of 0 is illegal and gives a latency of 3 clocks.
- R4: A byte lane whose enable is low drives zero. With no read slot due in a cycle, both enables are low. The upper lane is bits [15:8] with enable bit 1; the lower lane is bits [7:0] with enable bit 0.
- R5: A `mask` bit (bit 1 for the upper lane, bit 0 for the lower lane) sampled at edge m forces the enable of that lane low in cycle m+2, whatever read slot is due then.
- R6: A write beat sampled at edge w gives `wr_en`=1, `wr_data` equal to the sampled word and `wr_be` equal to the inverse of the `mask` sampled at the same edge, all in cycle w+1. Without a write beat, `wr_en` and `wr_be` are 0.
- R7: A burst stop at edge p drops the read beat at edge p and every later beat until the next read start. Beats accepted before edge p still reach the output.
- R8: A precharge at edge p lets a read reach the output only in cycles up to p+2. From cycle p+3 on, the output stays disabled until a new read start. Beats that land before p+3 are still accepted, which includes beats after edge p when the latency is short.
- R9: A write beat at edge w cancels every read slot still in flight. The enables are low in cycle w+1, and read beats stay ignored until the next read start.
- R10: A read start (`rd_start` together with `rd_beat`) is always accepted. It may follow another read on the next cycle or interrupt an ended burst, and it reopens the pipeline for the beats that follow.
- R11: Read beats without a start, while the pipeline is closed, have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_mode | input | 2 | Read latency code (1, 2, 3; 0 means 3) |
| rd_beat | input | 1 | A read word is offered on `rd_word` this cycle |
| rd_start | input | 1 | This beat is the first of a new read command |
| rd_word | input | 16 | Read word from the array |
| mask | input | 2 | Byte mask, bit 1 upper lane, bit 0 lower lane |
| wr_issue | input | 1 | Write beat this cycle |
| wr_word | input | 16 | Write word from the data pins |
| pchg | input | 1 | Precharge command strobe |
| bstop | input | 1 | Burst stop command strobe |
| dq_out | output | 16 | Output data; a disabled lane reads as zero |
| dq_oe | output | 2 | Per-lane output enable |
| wr_en | output | 1 | Registered write strobe toward the array |
| wr_data | output | 16 | Registered write word |
| wr_be | output | 2 | Registered per-byte write enable |

## Verification
The properties take for granted that at most one of read start, write, precharge and burst stop is raised in a cycle. They also assume a read start always comes with a beat and that `lat_mode` holds steady across the beats of a burst. The mask and precharge properties are qualified by a count of cycles since reset, so they never reach back into reset. The stimulus drives each command strobe alone, changes the latency code only after an idle gap long enough to drain the pipeline, and holds all inputs low during reset.

// File: rtl/rdp_pkg.sv
// Package for the read-latency / byte-mask output pipeline.
// Holds the latency-code width, the latency decode rule and the
// termination state encoding shared by the submodules.
package rdp_pkg;

    // Width of the programmable latency code.
    localparam int LAT_CODE_W = 2;

    // States of the read-termination controller.
    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,   // closed: only a read start is accepted
        TS_OPEN  = 2'd1,   // burst running: every beat accepted
        TS_DRAIN = 2'd2    // after precharge: beats accepted while they land in time
    } term_st_e;

    // Turns a latency code into a clock count; code 0 is illegal and means 3.
    function automatic logic [LAT_CODE_W-1:0] lat_decode(input logic [LAT_CODE_W-1:0] code);
        return (code == '0) ? LAT_CODE_W'(3) : code;
    endfunction

endpackage

// File: rtl/rdp_slot_chain.sv
// Latency shift register for read slots.
// Each stage holds a valid bit and a word. A new slot enters the stage whose
// distance from the head equals its latency, so it reaches the head (last
// stage) after exactly that many clocks. A flush clears every stage.
// Assumes the insert latency stays fixed while slots are in flight.
module rdp_slot_chain #(
    parameter  int DW    = 16,
    parameter  int DEPTH = 3,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ins_en,
    input  logic [LW-1:0] ins_lat,
    input  logic [DW-1:0] ins_word,
    input  logic          flush,
    output logic          head_vld,
    output logic [DW-1:0] head_word
);

    logic [DEPTH-1:0] vld_q;
    logic [DW-1:0]    word_q  [DEPTH];
    logic [DEPTH-1:0] vld_in;
    logic [DW-1:0]    word_in [DEPTH];

    // Shift-in source for each stage: stage 0 takes an empty slot.
    generate
        for (genvar k = 0; k < DEPTH; k++) begin : g_src
            if (k == 0) begin : g_first
                assign vld_in[k]  = 1'b0;
                assign word_in[k] = '0;
            end else begin : g_next
                assign vld_in[k]  = vld_q[k-1];
                assign word_in[k] = word_q[k-1];
            end
        end
    endgenerate

    // Stage update: clear on reset or flush, else insert or shift.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                word_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (ins_en && (ins_lat == LW'(DEPTH - k))) begin
                    vld_q[k]  <= 1'b1;
                    word_q[k] <= ins_word;
                end else begin
                    vld_q[k]  <= vld_in[k];
                    word_q[k] <= word_in[k];
                end
            end
        end
    end

    assign head_vld  = vld_q[DEPTH-1];
    assign head_word = word_q[DEPTH-1];

endmodule

// File: rtl/rdp_mask_delay.sv
// Fixed-depth delay line for the read byte masks.
// The value sampled at one edge appears at the output DLY clocks later.
// Assumes DLY is at least 1.
module rdp_mask_delay #(
    parameter int LANES = 2,
    parameter int DLY   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mask_in,
    output logic [LANES-1:0] mask_dly
);

    logic [LANES-1:0] pipe_q [DLY];

    // Shift the mask one stage per clock; stage 0 takes the live input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DLY; k++) begin
                pipe_q[k] <= '0;
            end
        end else begin
            pipe_q[0] <= mask_in;
            for (int k = 1; k < DLY; k++) begin
                pipe_q[k] <= pipe_q[k-1];
            end
        end
    end

    assign mask_dly = pipe_q[DLY-1];

endmodule

// File: rtl/rdp_term_ctl.sv
// Read termination controller.
// Decides each cycle whether the offered read beat enters the latency chain.
// A read start always opens the burst. A burst stop or a write closes it at
// once. A precharge keeps accepting only the beats that land within FLOAT_DLY
// clocks of it, then closes. Assumes one command strobe per cycle and
// FLOAT_DLY >= the largest latency.
module rdp_term_ctl
    import rdp_pkg::*;
#(
    parameter  int MAXLAT    = 3,
    parameter  int FLOAT_DLY = 3,
    localparam int LW        = $clog2(MAXLAT + 1),
    localparam int CW        = $clog2(FLOAT_DLY + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] lat,
    input  logic          rd_beat,
    input  logic          rd_start,
    input  logic          wr_issue,
    input  logic          pchg,
    input  logic          bstop,
    output logic          accept
);

    term_st_e      st_q, st_d;
    logic [CW-1:0] grace_q, grace_d;
    logic [CW-1:0] rem;

    // Next-state and accept decision for the current beat.
    always_comb begin
        rem = grace_q;
        if (pchg) begin
            rem = CW'(FLOAT_DLY) - CW'(lat);
        end
        accept  = 1'b0;
        st_d    = st_q;
        grace_d = grace_q;
        if (rd_start) begin
            accept  = rd_beat;
            st_d    = TS_OPEN;
            grace_d = '0;
        end else if (bstop || wr_issue) begin
            st_d    = TS_IDLE;
            grace_d = '0;
        end else if ((st_q != TS_IDLE) && (pchg || (st_q == TS_DRAIN))) begin
            accept = rd_beat && (rem != '0);
            if (rem <= CW'(1)) begin
                st_d    = TS_IDLE;
                grace_d = '0;
            end else begin
                st_d    = TS_DRAIN;
                grace_d = rem - CW'(1);
            end
        end else if (st_q == TS_OPEN) begin
            accept = rd_beat;
        end
    end

    // State register; reset leaves the pipeline closed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= TS_IDLE;
            grace_q <= '0;
        end else begin
            st_q    <= st_d;
            grace_q <= grace_d;
        end
    end

endmodule

// File: rtl/rdp_write_gate.sv
// Write-side byte gating.
// Registers a write beat with its word and a per-byte enable formed from the
// mask sampled at the same edge, so the mask acts with no extra latency.
module rdp_write_gate #(
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_issue,
    input  logic [DW-1:0]    wr_word,
    input  logic [LANES-1:0] mask,
    output logic             wr_en,
    output logic [DW-1:0]    wr_data,
    output logic [LANES-1:0] wr_be
);

    // Capture the write beat; byte enables are zero between beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_data <= '0;
            wr_be   <= '0;
        end else begin
            wr_en <= wr_issue;
            wr_be <= wr_issue ? ~mask : '0;
            if (wr_issue) begin
                wr_data <= wr_word;
            end
        end
    end

endmodule

// File: rtl/sdram_rdout_pipe.sv
// Top of the read-latency and byte-mask output pipeline.
// Accepts read beats from the array, delays them by the programmed latency,
// and drives them per byte lane. Lane enables are removed by the read mask
// two clocks after sampling. Command strobes end or restart bursts, and the
// write path gates bytes by the same-cycle mask. Assumes the command strobes
// are mutually exclusive and lat_mode is held across a burst.
module sdram_rdout_pipe
    import rdp_pkg::*;
#(
    parameter int DW        = 16,
    parameter int LANES     = 2,
    parameter int MAXLAT    = 3,
    parameter int MASK_DLY  = 2,
    parameter int FLOAT_DLY = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LAT_CODE_W-1:0] lat_mode,
    input  logic                  rd_beat,
    input  logic                  rd_start,
    input  logic [DW-1:0]         rd_word,
    input  logic [LANES-1:0]      mask,
    input  logic                  wr_issue,
    input  logic [DW-1:0]         wr_word,
    input  logic                  pchg,
    input  logic                  bstop,
    output logic [DW-1:0]         dq_out,
    output logic [LANES-1:0]      dq_oe,
    output logic                  wr_en,
    output logic [DW-1:0]         wr_data,
    output logic [LANES-1:0]      wr_be
);

    localparam int LW     = $clog2(MAXLAT + 1);
    localparam int LANE_W = DW / LANES;

    logic [LW-1:0]    lat;
    logic             accept;
    logic             head_vld;
    logic [DW-1:0]    head_word;
    logic [LANES-1:0] mask_late;

    // Latency in clocks from the mode code.
    always_comb begin
        lat = LW'(lat_decode(lat_mode));
    end

    rdp_term_ctl #(
        .MAXLAT    (MAXLAT),
        .FLOAT_DLY (FLOAT_DLY)
    ) u_term (
        .clk      (clk),
        .rst_n    (rst_n),
        .lat      (lat),
        .rd_beat  (rd_beat),
        .rd_start (rd_start),
        .wr_issue (wr_issue),
        .pchg     (pchg),
        .bstop    (bstop),
        .accept   (accept)
    );

    rdp_slot_chain #(
        .DW    (DW),
        .DEPTH (MAXLAT)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .ins_en    (accept),
        .ins_lat   (lat),
        .ins_word  (rd_word),
        .flush     (wr_issue),
        .head_vld  (head_vld),
        .head_word (head_word)
    );

    rdp_mask_delay #(
        .LANES (LANES),
        .DLY   (MASK_DLY)
    ) u_mdly (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_in  (mask),
        .mask_dly (mask_late)
    );

    rdp_write_gate #(
        .DW    (DW),
        .LANES (LANES)
    ) u_wgate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_issue (wr_issue),
        .wr_word  (wr_word),
        .mask     (mask),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_be    (wr_be)
    );

    // Per-lane drive: a lane is enabled by a due slot and an unmasked delayed mask.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign dq_oe[i] = head_vld & ~mask_late[i];
            assign dq_out[i*LANE_W +: LANE_W] =
                dq_oe[i] ? head_word[i*LANE_W +: LANE_W] : '0;
        end
    endgenerate

endmodule

// File: rtl/sdram_rdout_pipe_chk.sv
// Property checker for sdram_rdout_pipe, attached with bind below.
// Watches ports only; a cycle counter keeps multi-cycle look-backs
// from reaching into reset.
module sdram_rdout_pipe_chk #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       lat_mode,
    input logic             rd_beat,
    input logic             rd_start,
    input logic [LANES-1:0] mask,
    input logic             wr_issue,
    input logic             pchg,
    input logic             bstop,
    input logic [LANES-1:0] dq_oe,
    input logic             wr_en,
    input logic [LANES-1:0] wr_be
);

    logic [1:0] since_rst;

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    p_one_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_start, wr_issue, pchg, bstop}));

    p_start_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |-> rd_beat);

    p_lat_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_beat && !rd_start && since_rst != 2'd0) |-> $stable(lat_mode));

    p_wr_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |=> (wr_en && (wr_be == ~$past(mask))));

    p_wr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_issue |=> (!wr_en && (wr_be == '0)));

    p_wr_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_issue |=> (dq_oe == '0));

    p_mask_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (($past(mask, 2) & dq_oe) == '0));

    p_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) && $past(pchg, 3) && !$past(rd_start, 2)
         && !$past(rd_start, 1)) |-> (dq_oe == '0));

endmodule

bind sdram_rdout_pipe sdram_rdout_pipe_chk #(.LANES(LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lat_mode (lat_mode),
    .rd_beat  (rd_beat),
    .rd_start (rd_start),
    .mask     (mask),
    .wr_issue (wr_issue),
    .pchg     (pchg),
    .bstop    (bstop),
    .dq_oe    (dq_oe),
    .wr_en    (wr_en),
    .wr_be    (wr_be)
);

// File: tb/sim_sdram_rdout_pipe.sv
// Bench for sdram_rdout_pipe: a behavioural model keyed by cycle number
// predicts every output and is compared once per clock.
module sim_sdram_rdout_pipe;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  lat_mode;
    logic        rd_beat, rd_start, wr_issue, pchg, bstop;
    logic [15:0] rd_word, wr_word;
    logic [1:0]  mask;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [1:0]  wr_be;

    always #10 clk = ~clk;

    sdram_rdout_pipe u0 (
        .clk(clk), .rst_n(rst_n), .lat_mode(lat_mode),
        .rd_beat(rd_beat), .rd_start(rd_start), .rd_word(rd_word),
        .mask(mask), .wr_issue(wr_issue), .wr_word(wr_word),
        .pchg(pchg), .bstop(bstop), .dq_out(dq_out), .dq_oe(dq_oe),
        .wr_en(wr_en), .wr_data(wr_data), .wr_be(wr_be)
    );

    integer checks = 0;
    integer errors = 0;
    integer cyc    = 0;
    string  rtag   = "R4";

    // Model state: read slots due per cycle, mask history, write expectation.
    bit          sv [16];
    logic [15:0] sd [16];
    logic [1:0]  mh [16];
    bit          m_open = 1'b0;
    integer      cutoff = 32'h7fffffff;
    bit          ew_en = 1'b0;
    logic [15:0] ew_d = '0;
    logic [1:0]  ew_be = '0;
    logic [15:0] seq = 16'h0100;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h",
                     req, what, cyc, act, exp);
        end
    endtask

    // One cycle: compare outputs, drive inputs, update model, cross the edge.
    task automatic step(input bit rs, input bit rb, input bit wi, input bit pc,
                        input bit bs, input logic [1:0] mk,
                        input logic [15:0] rw, input logic [15:0] ww);
        int          slot;
        logic [1:0]  eo;
        logic [15:0] ed;
        int          lat;
        bit          take;
        slot = cyc % 16;
        eo = sv[slot] ? 2'b11 : 2'b00;
        if (cyc >= 2) eo = eo & ~mh[(cyc - 2) % 16];
        ed = {eo[1] ? sd[slot][15:8] : 8'h00, eo[0] ? sd[slot][7:0] : 8'h00};
        check((dq_oe == eo) && (dq_out == ed), rtag, "read lanes",
              {14'd0, dq_oe, dq_out}, {14'd0, eo, ed});
        check((wr_en == ew_en) && (wr_be == ew_be) && (!ew_en || wr_data == ew_d),
              "R6", "write path", {13'd0, wr_en, wr_be, wr_data},
              {13'd0, ew_en, ew_be, ew_d});
        sv[slot] = 1'b0;

        rd_start = rs; rd_beat = rb | rs; wr_issue = wi; pchg = pc; bstop = bs;
        mask = mk; rd_word = rw; wr_word = ww;

        mh[slot] = mk;
        lat = (lat_mode == 2'd0) ? 3 : int'(lat_mode);
        ew_en = wi; ew_be = wi ? ~mk : 2'b00;
        if (wi) ew_d = ww;
        take = 1'b0;
        if (wi) begin
            m_open = 1'b0;
            for (int k = 1; k <= 3; k++) sv[(cyc + k) % 16] = 1'b0;
        end else if (rs) begin
            m_open = 1'b1; cutoff = 32'h7fffffff; take = 1'b1;
        end else if (bs) begin
            m_open = 1'b0;
        end else begin
            if (pc) cutoff = cyc + 3;
            take = rb && m_open && (cyc + lat < cutoff);
        end
        if (take) begin
            sv[(cyc + lat) % 16] = 1'b1;
            sd[(cyc + lat) % 16] = rw;
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 2'b00, 16'h0, 16'h0);
    endtask

    function automatic logic [15:0] nxt();
        seq = seq + 16'h0111;
        return seq;
    endfunction

    // All scenarios for one latency code.
    task automatic run_code(input logic [1:0] code);
        lat_mode = code;
        rtag = "R4"; idle(4);
        rtag = (code == 2'd0) ? "R3" : "R2";
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        idle(4);
        rtag = "R10";
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        idle(4);
        rtag = "R5";
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b01, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b10, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b11, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        idle(4);
        rtag = "R7";
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 1, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        idle(4);
        rtag = "R8";
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 1, 0, 2'b00, nxt(), 16'h0);
        for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        idle(4);
        rtag = "R9";
        step(1, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        step(0, 0, 1, 0, 0, 2'b01, 16'h0, nxt());
        step(0, 1, 1, 0, 0, 2'b10, nxt(), nxt());
        step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        idle(4);
        rtag = "R11";
        for (int k = 0; k < 3; k++) step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        idle(3);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lat_mode = 2'd1;
        rd_beat = 0; rd_start = 0; wr_issue = 0; pchg = 0; bstop = 0;
        mask = 2'b00; rd_word = '0; wr_word = '0;
        for (int k = 0; k < 16; k++) begin sv[k] = 0; sd[k] = '0; mh[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check((dq_oe == 2'b00) && (dq_out == 16'h0), "R1", "reset read outputs",
              {14'd0, dq_oe, dq_out}, 32'h0);
        check((wr_en == 1'b0) && (wr_be == 2'b00), "R1", "reset write outputs",
              {29'd0, wr_en, wr_be}, 32'h0);
        rst_n = 1'b1;
        rtag = "R1";
        for (int k = 0; k < 2; k++) step(0, 1, 0, 0, 0, 2'b00, nxt(), 16'h0);
        run_code(2'd1);
        run_code(2'd2);
        run_code(2'd3);
        run_code(2'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule